// File: doc/BRIEF.md
# Sequential Next-Block Instruction Prefetcher

This block sits beside a primary instruction cache and turns each cache miss into a demand fetch plus a speculative fetch of the following block. The demanded block is returned to the cache through a fill port. The speculative block is parked in a single-entry side buffer instead of the cache, so a wrong guess never evicts useful lines.

When the cache later misses on the parked block, the block is handed to the cache straight from the buffer, with no trip to the next level. The prefetch chain then moves one block forward. If the speculative fetch is still in flight when its block is missed on, the block waits for that response and does not issue a second request. A miss on any other block throws the buffer away and starts a new chain. Block addresses count in whole blocks and wrap from the top address to zero. The next memory level answers requests in the order it accepts them.

Top module: `seq_prefetch`

## Requirements
- R1: A miss on block A, when the buffer holds neither A nor a fetch of A, issues exactly two requests in this order: A, then A+1.
- R2: The response to a demand request appears on the fill port one cycle after it arrives, carrying the missed block address and the returned data. Every fill is a single-cycle pulse.
- R3: A response to a speculative request is kept in the buffer and never produces a fill on its own.
- R4: A miss on a block that is already present in the buffer fills from the buffer in the cycle after acceptance, issues no request for that block, and issues one request for the next block.
- R5: A miss on a block whose speculative fetch is still outstanding issues no new request for it. Its response is sent to the fill port, and the request for the next block follows.
- R6: A miss that does not match a block held in the buffer discards that block. A later miss on the discarded block is handled as in R1.
- R7: A miss that does not match an outstanding speculative fetch waits for that response and drops it without a fill. It then behaves as in R1. At most one speculative request is outstanding.
- R8: The next-block address of the highest block address is block zero.
- R9: During and right after reset, no fill and no memory request are driven, and a miss is accepted.
- R10: Only one miss is handled at a time. From acceptance until its fill, the miss port shows not-ready.
- R11: Once a memory request is raised, its valid and address stay unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Cache presents a missed block address |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_ready | output | 1 | Prefetcher can accept a miss this cycle |
| fill_valid | output | 1 | One-cycle pulse: block for the cache |
| fill_addr | output | ADDR_W | Block address of the fill |
| fill_data | output | DATA_W | Block contents of the fill |
| mem_req_valid | output | 1 | Request to the next memory level |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_rsp_valid | input | 1 | Response from the next level, in request order |
| mem_rsp_data | input | DATA_W | Returned block contents |

## Verification
A stale or wrong buffer tag shows up at the memory port at the very next miss. Either a request appears for a block that should have come from the buffer, or a request is missing for one that should not have. A corrupted buffer payload shows up as wrong fill data one cycle after a buffer hit. A lost pending flag shows up as a duplicated request, or as a fill made from a dropped response, within the latency of one memory response. The bench models the buffer contents from the miss sequence alone, so every request and every fill is compared as it happens.

// File: rtl/seq_prefetch_pkg.sv
package seq_prefetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEMAND_REQ,
    ST_NEXT_REQ,
    ST_DEMAND_WAIT,
    ST_PF_WAIT,
    ST_DRAIN
  } pf_state_t;
endpackage

// File: rtl/pf_side_entry.sv
module pf_side_entry #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_tag,
  input  logic              issue,
  input  logic              land,
  input  logic [DATA_W-1:0] land_data,
  input  logic              drop,
  output logic [ADDR_W-1:0] tag,
  output logic              valid,
  output logic              pend,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag   <= '0;
      valid <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (arm) begin
        tag   <= arm_tag;
        valid <= 1'b0;
      end
      if (issue) pend <= 1'b1;
      if (land) begin
        valid <= 1'b1;
        pend  <= 1'b0;
      end
      if (drop) pend <= 1'b0;
    end
  end

  // payload register kept reset-free so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (land) data <= land_data;
  end

  // R3: a response is parked only when a speculative fetch is open
  p_land_pend_r3: assert property (@(posedge clk) disable iff (rst)
    land |-> pend);

  // R7: never a second speculative request while one is open
  p_single_pf_r7: assert property (@(posedge clk) disable iff (rst)
    issue |-> !pend);
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import seq_prefetch_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [ADDR_W-1:0] sb_tag,
  input  logic              sb_valid,
  input  logic              sb_pend,
  input  logic [DATA_W-1:0] sb_data,
  output logic              sb_arm,
  output logic [ADDR_W-1:0] sb_arm_tag,
  output logic              sb_issue,
  output logic              sb_land,
  output logic              sb_drop
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  pf_state_t         st;
  logic [ADDR_W-1:0] cur;
  logic              dem_out;
  logic              accept, sb_hit, sb_wait, rsp_dem, rsp_spec;

  assign miss_ready    = (st == ST_IDLE) && !mem_rsp_valid;
  assign accept        = miss_valid && miss_ready;
  assign sb_hit        = sb_valid && (sb_tag == miss_addr);
  assign sb_wait       = sb_pend && (sb_tag == miss_addr);
  assign mem_req_valid = (st == ST_DEMAND_REQ) || (st == ST_NEXT_REQ);
  assign mem_req_addr  = (st == ST_DEMAND_REQ) ? cur : sb_tag;

  assign rsp_dem  = mem_rsp_valid && dem_out;
  assign rsp_spec = mem_rsp_valid && !dem_out;

  always_comb begin
    sb_arm     = 1'b0;
    sb_arm_tag = miss_addr + STEP;
    if (st == ST_IDLE) begin
      sb_arm = accept && !sb_pend;
    end else if ((st == ST_PF_WAIT) || (st == ST_DRAIN)) begin
      sb_arm     = rsp_spec;
      sb_arm_tag = cur + STEP;
    end
  end

  assign sb_issue = (st == ST_NEXT_REQ) && mem_req_ready;
  assign sb_drop  = rsp_spec && ((st == ST_PF_WAIT) || (st == ST_DRAIN));
  assign sb_land  = rsp_spec && (st != ST_PF_WAIT) && (st != ST_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= '0;
      dem_out    <= 1'b0;
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_data  <= '0;
    end else begin
      fill_valid <= 1'b0;
      if (rsp_dem) begin
        fill_valid <= 1'b1;
        fill_addr  <= cur;
        fill_data  <= mem_rsp_data;
        dem_out    <= 1'b0;
      end
      unique case (st)
        ST_IDLE: if (accept) begin
          cur <= miss_addr;
          if (sb_hit) begin
            fill_valid <= 1'b1;
            fill_addr  <= miss_addr;
            fill_data  <= sb_data;
            st         <= ST_NEXT_REQ;
          end else if (sb_wait) st <= ST_PF_WAIT;
          else if (sb_pend)     st <= ST_DRAIN;
          else                  st <= ST_DEMAND_REQ;
        end
        ST_DEMAND_REQ: if (mem_req_ready) begin
          dem_out <= 1'b1;
          st      <= ST_NEXT_REQ;
        end
        ST_NEXT_REQ: if (mem_req_ready)
          st <= (dem_out && !mem_rsp_valid) ? ST_DEMAND_WAIT : ST_IDLE;
        ST_DEMAND_WAIT: if (mem_rsp_valid) st <= ST_IDLE;
        ST_PF_WAIT: if (rsp_spec) begin
          fill_valid <= 1'b1;
          fill_addr  <= cur;
          fill_data  <= mem_rsp_data;
          st         <= ST_NEXT_REQ;
        end
        ST_DRAIN: if (rsp_spec) st <= ST_DEMAND_REQ;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: quiet outputs right after a reset cycle
  p_rst_quiet_r9: assert property (@(posedge clk)
    rst |=> (!fill_valid && !mem_req_valid));

  // R10: an accepted miss closes the port on the next cycle
  p_one_miss_r10: assert property (@(posedge clk) disable iff (rst)
    accept |=> !miss_ready);

  // R11: a raised request holds until taken
  p_hold_req_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2: fills are one-cycle pulses
  p_fill_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid);

  // R4: buffer hit fills next cycle and asks for the following block
  p_hit_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && sb_hit) |=> (fill_valid && mem_req_valid &&
                            (mem_req_addr == ADDR_W'($past(miss_addr) + STEP))));
endmodule

// File: rtl/seq_prefetch.sv
module seq_prefetch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  logic [ADDR_W-1:0] sb_tag, sb_arm_tag;
  logic              sb_valid, sb_pend, sb_arm, sb_issue, sb_land, sb_drop;
  logic [DATA_W-1:0] sb_data;

  pf_side_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
    .clk(clk), .rst(rst),
    .arm(sb_arm), .arm_tag(sb_arm_tag), .issue(sb_issue),
    .land(sb_land), .land_data(mem_rsp_data), .drop(sb_drop),
    .tag(sb_tag), .valid(sb_valid), .pend(sb_pend), .data(sb_data)
  );

  pf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .sb_tag(sb_tag), .sb_valid(sb_valid), .sb_pend(sb_pend), .sb_data(sb_data),
    .sb_arm(sb_arm), .sb_arm_tag(sb_arm_tag), .sb_issue(sb_issue),
    .sb_land(sb_land), .sb_drop(sb_drop)
  );
endmodule

// File: tb/sim_seq_prefetch.sv
module sim_seq_prefetch;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NMISS = 700;

  logic          clk = 1'b0;
  logic          rst;
  logic          miss_valid, miss_ready;
  logic [AW-1:0] miss_addr;
  logic          fill_valid;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic          mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_rsp_data;

  always #5 clk = ~clk;

  seq_prefetch #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5AC3_0F96;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // bench model of the side buffer
  logic [AW-1:0] m_tag;
  bit            m_has, m_landed;
  int            m_gen;
  // expected requests
  int unsigned   eq_addr[$];
  string         eq_tag[$];
  int            eq_gen[$];
  // memory model
  int unsigned   rq_addr[$];
  int            rq_gen[$];
  longint        rq_due[$];
  longint        last_due;
  // miss driver
  bit            m_out, presenting, ready_seen;
  logic [AW-1:0] cur_a, last_a, exp_fill_a;
  string         fill_tag;
  longint        acc_cyc, cyc;
  int            sent, gap;
  bit            prev_stall;
  logic [AW-1:0] prev_addr;
  logic [AW-1:0] dir_list [10];

  function automatic logic [AW-1:0] pick_addr(input int n, input logic [AW-1:0] last);
    int r;
    if (n < 10) return dir_list[n];
    r = $urandom % 10;
    if (r < 6)       return last + AW'(1);
    else if (r == 6) return last + AW'(2);
    else if (r == 7) return AW'($urandom);
    else if (r == 8) return AW'(8'hFE + ($urandom % 2));
    else             return last;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    dir_list = '{8'h10, 8'h11, 8'h12, 8'hFE, 8'hFF, 8'h00, 8'h40, 8'h30, 8'h41, 8'h31};
    rst = 1'b1; miss_valid = 1'b0; miss_addr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    m_has = 0; m_landed = 0; m_gen = 0; m_tag = '0; last_due = 0;
    m_out = 0; presenting = 0; sent = 0; gap = 0; cyc = 0; acc_cyc = 0;
    prev_stall = 0; prev_addr = '0; last_a = 8'h0F; ready_seen = 0;
    exp_fill_a = '0; fill_tag = "R2"; cur_a = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!fill_valid, "R9", "fill_valid in reset", longint'(fill_valid), 0);
    chk(!mem_req_valid, "R9", "mem_req_valid in reset", longint'(mem_req_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!fill_valid && !mem_req_valid, "R9", "outputs after reset",
        longint'({fill_valid, mem_req_valid}), 0);
    chk(miss_ready, "R9", "miss_ready after reset", longint'(miss_ready), 1);

    forever begin
      @(negedge clk);
      cyc++;
      // drive inputs for the coming edge
      mem_req_ready = ($urandom % 4) != 0;
      if (rq_addr.size() > 0 && rq_due[0] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = blk(AW'(rq_addr[0]));
        if (rq_gen[0] == m_gen && m_has) m_landed = 1;
        void'(rq_addr.pop_front()); void'(rq_gen.pop_front()); void'(rq_due.pop_front());
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (!m_out && !presenting && gap == 0 && sent < NMISS) begin
        cur_a = pick_addr(sent, last_a);
        presenting = 1;
      end
      miss_valid = presenting;
      miss_addr  = cur_a;
      #1;
      // R11: held request
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R11", "request held",
            longint'(mem_req_addr), longint'(prev_addr));
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      // fills
      if (fill_valid) begin
        if (!m_out) begin
          chk(0, "R3", "unexpected fill", longint'(fill_addr), -1);
        end else begin
          chk(fill_addr == exp_fill_a, fill_tag, "fill address",
              longint'(fill_addr), longint'(exp_fill_a));
          chk(fill_data == blk(exp_fill_a), fill_tag, "fill data",
              longint'(fill_data), longint'(blk(exp_fill_a)));
          if (fill_tag == "R4")
            chk(cyc == acc_cyc + 1, "R4", "fill cycle after buffer hit", cyc, acc_cyc + 1);
          chk(!ready_seen, "R10", "miss_ready low while miss open", longint'(ready_seen), 0);
          m_out = 0;
          gap   = $urandom % 7;
        end
      end
      if (m_out && miss_ready) ready_seen = 1;
      // request handshake
      if (mem_req_valid && mem_req_ready) begin
        if (eq_addr.size() == 0) begin
          chk(0, "R1", "unexpected request", longint'(mem_req_addr), -1);
        end else begin
          chk(mem_req_addr == AW'(eq_addr[0]), eq_tag[0], "request address",
              longint'(mem_req_addr), longint'(eq_addr[0]));
          rq_gen.push_back(eq_gen[0]);
          void'(eq_addr.pop_front()); void'(eq_tag.pop_front()); void'(eq_gen.pop_front());
        end
        rq_addr.push_back(32'(mem_req_addr));
        last_due = (cyc + 1 + ($urandom % 5) > last_due + 1) ?
                   cyc + 1 + ($urandom % 5) : last_due + 1;
        rq_due.push_back(last_due);
        if (rq_gen.size() < rq_addr.size()) rq_gen.push_back(-1);
      end
      // miss acceptance and model update
      if (miss_valid && miss_ready) begin
        logic [AW-1:0] nx;
        string tg;
        nx = miss_addr + AW'(1);
        if (m_has && m_tag == miss_addr) begin
          tg = m_landed ? "R4" : "R5";
          fill_tag = tg;
        end else begin
          tg = !m_has ? "R1" : (m_landed ? "R6" : "R7");
          fill_tag = "R2";
          eq_addr.push_back(32'(miss_addr)); eq_tag.push_back(tg); eq_gen.push_back(-1);
        end
        m_gen++;
        eq_addr.push_back(32'(nx)); eq_tag.push_back(nx == '0 ? "R8" : tg);
        eq_gen.push_back(m_gen);
        m_has = 1; m_tag = nx; m_landed = 0;
        exp_fill_a = miss_addr; last_a = miss_addr;
        m_out = 1; ready_seen = 0; acc_cyc = cyc; presenting = 0; sent++;
      end
      if (!m_out && !presenting && gap > 0) gap--;
      if (sent == NMISS && !m_out && eq_addr.size() == 0 && rq_addr.size() == 0) break;
      if (cyc > 150000) begin
        chk(0, "R10", "watchdog expired", cyc, 150000);
        break;
      end
    end
    miss_valid = 1'b0; mem_rsp_valid = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    chk(!fill_valid && !mem_req_valid, "R3", "quiet after last miss",
        longint'({fill_valid, mem_req_valid}), 0);
    chk(eq_addr.size() == 0, "R1", "expected requests all seen", eq_addr.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule